// File: doc/BRIEF.md
# Byte FIFO Pair with Polled Status Word

This block holds two byte queues: one for the transmit direction and one for the receive direction. Each queue has a push port that writes a byte and a pop port that reads one. Each queue can hold up to 64 bytes. Software learns the state of both queues by polling a single 16-bit status word. Each direction has a 6-bit fill count and a separate full flag in that word.

Because a 6-bit field cannot show 64, the count field reads 0 when a queue is full. Only the full flag shows that state. So software must test both the flag and the count to learn whether any data is waiting.

A single queue-mode input selects the depth. When it is high, each queue holds 64 entries. When it is low, each queue becomes a one-byte holding register. Any change of this input empties both queues.

Top module: `uart_fifo_status`

## Requirements
- R1: After reset the status word is 0x0000, and both read-data outputs are 0x00.
- R2: Bytes leave each queue in the order they were pushed. An accepted pop presents the head byte on the read-data output one cycle after the pop.
- R3: Status word layout: bit 14 is the transmit full flag, bits 13:8 are the transmit count, bit 6 is the receive full flag, bits 5:0 are the receive count, and bits 15 and 7 always read 0.
- R4: In queue mode the full flag is 0 while a queue holds 0 to 63 bytes. The flag is 1 at 64 bytes, and the count field then reads 0.
- R5: A push into a full queue without a pop in the same cycle is dropped. The count and the stored bytes do not change.
- R6: A pop from an empty queue leaves the read-data output and the count unchanged.
- R7: A push and a pop in the same cycle on a non-empty queue (including a full one) leave the count unchanged. On an empty queue, the pop is ignored and the push is taken.
- R8: With queue mode off, each queue holds one byte. Its count reads 1 and its full flag reads 1 while the byte is held, and further pushes are dropped.
- R9: In the cycle the queue-mode input changes, both queues are emptied, and the push and pop inputs of that cycle are ignored.
- R10: A direction holds data exactly when its full flag is 1 or its count field is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | Queue mode: 1 = 64-deep, 0 = single holding register |
| tx_push | input | 1 | Write a byte into the transmit queue |
| tx_wdata | input | 8 | Transmit byte to write |
| tx_pop | input | 1 | Take the head byte of the transmit queue |
| tx_rdata | output | 8 | Last byte popped from the transmit queue |
| rx_push | input | 1 | Write a byte into the receive queue |
| rx_wdata | input | 8 | Receive byte to write |
| rx_pop | input | 1 | Take the head byte of the receive queue |
| rx_rdata | output | 8 | Last byte popped from the receive queue |
| status | output | 16 | Packed full flags and counts of both queues |

## Verification
A wrong occupancy counter shows up in the status word at the very next sample. It shows as a count off by one, as a full flag that arrives one push early or late, or as a count field that does not wrap to 0 at 64. A pointer fault only shows when a byte is popped. The bench therefore fills a queue to 64 bytes and drains it completely, comparing every byte in order. This exposes a dropped or duplicated entry within one pass of the ring. Faults in the mode-change flush and in the holding-register mode appear as a nonzero status one cycle after the mode input toggles.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int FIFO_DEPTH  = 64;
  localparam int PTR_W       = $clog2(FIFO_DEPTH);
  localparam int OCC_W       = PTR_W + 1;
  localparam int CNT_FIELD_W = 6;
  localparam int STATUS_W    = 16;

  typedef logic [OCC_W-1:0]    occ_t;
  typedef logic [PTR_W-1:0]    ptr_t;
  typedef logic [STATUS_W-1:0] status_t;

  // Occupancy after one cycle of accepted push/pop
  function automatic occ_t occ_next(occ_t cur, logic inc, logic dec);
    case ({inc, dec})
      2'b10:   return cur + occ_t'(1);
      2'b01:   return cur - occ_t'(1);
      default: return cur;
    endcase
  endfunction

  // Ring pointer advance with explicit wrap
  function automatic ptr_t ptr_inc(ptr_t p);
    return (p == ptr_t'(FIFO_DEPTH - 1)) ? '0 : p + ptr_t'(1);
  endfunction

  // Status layout: [14] tx full, [13:8] tx count, [6] rx full, [5:0] rx count
  function automatic status_t pack_status(logic tx_full, occ_t tx_occ,
                                          logic rx_full, occ_t rx_occ);
    status_t s;
    s        = '0;
    s[14]    = tx_full;
    s[13:8]  = tx_occ[CNT_FIELD_W-1:0];
    s[6]     = rx_full;
    s[5:0]   = rx_occ[CNT_FIELD_W-1:0];
    return s;
  endfunction
endpackage

// File: rtl/fifo_byte_queue.sv
module fifo_byte_queue
  import uart_fifo_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output occ_t          occ,
  output logic          full
);
  logic [DW-1:0] mem [FIFO_DEPTH];
  ptr_t wptr, rptr;
  logic en_q;

  // Named internal events
  logic mode_chg, empty_w, push_ok, pop_ok;
  occ_t cap;

  assign mode_chg = fifo_en ^ en_q;
  assign cap      = fifo_en ? occ_t'(FIFO_DEPTH) : occ_t'(1);
  assign full     = (occ == cap);
  assign empty_w  = (occ == '0);
  assign pop_ok   = pop && !empty_w && !mode_chg;
  assign push_ok  = push && (!full || pop_ok) && !mode_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      occ   <= '0;
      wptr  <= '0;
      rptr  <= '0;
      rdata <= '0;
    end else begin
      en_q <= fifo_en;
      if (mode_chg) begin
        occ  <= '0;
        wptr <= '0;
        rptr <= '0;
      end else begin
        occ <= occ_next(occ, push_ok, pop_ok);
        if (push_ok) wptr <= ptr_inc(wptr);
        if (pop_ok) begin
          rptr  <= ptr_inc(rptr);
          rdata <= mem[rptr];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  // R5
  drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !mode_chg) |=> $stable(occ));

  // R6
  empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_w && pop && !push && !mode_chg) |=> ($stable(rdata) && occ == '0));

  // R7
  pushpop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty_w && !mode_chg) |=> $stable(occ));

  // R8
  single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !mode_chg) |-> (occ <= occ_t'(1)));

  // R9
  mode_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (occ == '0));
endmodule

// File: rtl/status_word_pack.sv
module status_word_pack
  import uart_fifo_pkg::*;
(
  input  logic    tx_full,
  input  occ_t    tx_occ,
  input  logic    rx_full,
  input  occ_t    rx_occ,
  output status_t status
);
  assign status = pack_status(tx_full, tx_occ, rx_full, rx_occ);
endmodule

// File: rtl/uart_fifo_status.sv
module uart_fifo_status
  import uart_fifo_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fifo_en,
  input  logic                tx_push,
  input  logic [DW-1:0]       tx_wdata,
  input  logic                tx_pop,
  output logic [DW-1:0]       tx_rdata,
  input  logic                rx_push,
  input  logic [DW-1:0]       rx_wdata,
  input  logic                rx_pop,
  output logic [DW-1:0]       rx_rdata,
  output logic [STATUS_W-1:0] status
);
  localparam int NCH = 2;  // channel 0 = transmit, 1 = receive

  logic [NCH-1:0] ch_push, ch_pop, ch_full;
  logic [DW-1:0]  ch_wdata [NCH];
  logic [DW-1:0]  ch_rdata [NCH];
  occ_t           ch_occ   [NCH];

  assign ch_push     = {rx_push, tx_push};
  assign ch_pop      = {rx_pop, tx_pop};
  assign ch_wdata[0] = tx_wdata;
  assign ch_wdata[1] = rx_wdata;
  assign tx_rdata    = ch_rdata[0];
  assign rx_rdata    = ch_rdata[1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    fifo_byte_queue #(.DW(DW)) u_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .fifo_en (fifo_en),
      .push    (ch_push[c]),
      .wdata   (ch_wdata[c]),
      .pop     (ch_pop[c]),
      .rdata   (ch_rdata[c]),
      .occ     (ch_occ[c]),
      .full    (ch_full[c])
    );
  end

  status_word_pack u_pack (
    .tx_full (ch_full[0]),
    .tx_occ  (ch_occ[0]),
    .rx_full (ch_full[1]),
    .rx_occ  (ch_occ[1]),
    .status  (status)
  );

  // R4
  tx_full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[14] && fifo_en) |-> (status[13:8] == '0));

  // R4
  rx_full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6] && fifo_en) |-> (status[5:0] == '0));

  // R1
  reset_status_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (status == '0));
endmodule

// File: tb/tb_uart_fifo_status.sv
module tb_uart_fifo_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_en = 1'b0;
  logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0]  tx_wdata = '0, rx_wdata = '0;
  logic [7:0]  tx_rdata, rx_rdata;
  logic [15:0] status;
  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  uart_fifo_status dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .status(status)
  );

  // Vector: txw, txd[8], txr, rxw, rxd[8], rxr, exp_status[16], exp_tx[8], exp_rx[8]
  localparam int NV = 9;
  localparam logic [51:0] VEC [NV] = '{
    {1'b1, 8'hA1, 1'b0, 1'b1, 8'h11, 1'b0, 16'h0101, 8'h00, 8'h00},
    {1'b1, 8'hA2, 1'b0, 1'b1, 8'h22, 1'b0, 16'h0202, 8'h00, 8'h00},
    {1'b1, 8'hA3, 1'b1, 1'b0, 8'h00, 1'b0, 16'h0202, 8'hA1, 8'h00},
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 16'h0201, 8'hA1, 8'h11},
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 16'h0100, 8'hA2, 8'h22},
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 16'h0100, 8'hA2, 8'h22},
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 16'h0000, 8'hA3, 8'h22},
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 16'h0000, 8'hA3, 8'h22},
    {1'b1, 8'hB4, 1'b1, 1'b0, 8'h00, 1'b0, 16'h0100, 8'hA3, 8'h22}
  };

  function automatic logic has_rx_data(logic [15:0] s);
    return s[6] | (s[5:0] != 6'd0);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; inputs are held over one rising edge
  task automatic cyc(input logic tw, input logic [7:0] td, input logic tr,
                     input logic rw, input logic [7:0] rd, input logic rr);
    tx_push = tw; tx_wdata = td; tx_pop = tr;
    rx_push = rw; rx_wdata = rd; rx_pop = rr;
    @(negedge clk);
    tx_push = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual still running expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status, 16'h0000);
    chk("R1 tx_rdata", {8'h0, tx_rdata}, 16'h0000);
    chk("R1 rx_rdata", {8'h0, rx_rdata}, 16'h0000);

    fifo_en = 1'b1;
    cyc(0, 8'h0, 0, 0, 8'h0, 0);  // mode change flush cycle

    // Table walk: R2 order, R3 layout, R6 empty pop, R7 push+pop
    for (int i = 0; i < NV; i++) begin
      logic [51:0] v;
      v = VEC[i];
      cyc(v[51], v[50:43], v[42], v[41], v[40:33], v[32]);
      chk("R3/R7 table status", status, v[31:16]);
      chk("R2/R6 table tx_rdata", {8'h0, tx_rdata}, {8'h0, v[15:8]});
      chk("R2/R6 table rx_rdata", {8'h0, rx_rdata}, {8'h0, v[7:0]});
    end

    // R9: toggling mode empties both queues
    fifo_en = 1'b0;
    cyc(0, 8'h0, 0, 0, 8'h0, 0);
    fifo_en = 1'b1;
    cyc(0, 8'h0, 0, 0, 8'h0, 0);
    chk("R9 flush", status, 16'h0000);

    // R4: fill both to 63 then 64
    for (int i = 0; i < 63; i++) cyc(1, 8'(i), 0, 1, ~8'(i), 0);
    chk("R4 at 63", status, 16'h3F3F);
    cyc(1, 8'd63, 0, 1, ~8'd63, 0);
    chk("R4 at 64 wraps", status, 16'h4040);
    // R10: full receive queue with count field 0 still holds data
    chk("R10 full present", {15'h0, has_rx_data(status)}, 16'h0001);
    // R5: push when full dropped
    cyc(1, 8'hEE, 0, 0, 8'h0, 0);
    chk("R5 push when full", status, 16'h4040);
    // R7: push and pop while full
    cyc(1, 8'hDD, 1, 0, 8'h0, 0);
    chk("R7 full push+pop status", status, 16'h4040);
    chk("R7 full push+pop data", {8'h0, tx_rdata}, 16'h0000);

    // R2/R5: drain in order; 0xEE never appears
    for (int i = 1; i < 64; i++) begin
      cyc(0, 8'h0, 1, 0, 8'h0, 0);
      chk("R2 drain order", {8'h0, tx_rdata}, {8'h0, 8'(i)});
    end
    cyc(0, 8'h0, 1, 0, 8'h0, 0);
    chk("R5 last byte", {8'h0, tx_rdata}, 16'h00DD);
    chk("R3 tx empty", status, 16'h0040);
    // R6: pop when empty holds data and count
    cyc(0, 8'h0, 1, 0, 8'h0, 0);
    chk("R6 empty pop data", {8'h0, tx_rdata}, 16'h00DD);
    chk("R6 empty pop status", status, 16'h0040);

    // R9: leave queue mode
    fifo_en = 1'b0;
    cyc(0, 8'h0, 0, 0, 8'h0, 0);
    chk("R9 flush on disable", status, 16'h0000);
    chk("R10 empty", {15'h0, has_rx_data(status)}, 16'h0000);

    // R8: single holding register
    cyc(0, 8'h0, 0, 1, 8'h5A, 0);
    chk("R8 one entry", status, 16'h0041);
    cyc(0, 8'h0, 0, 1, 8'h6B, 0);
    chk("R8 second push dropped", status, 16'h0041);
    cyc(1, 8'h77, 0, 0, 8'h0, 0);
    chk("R8 tx holding", status, 16'h4141);
    cyc(0, 8'h0, 0, 0, 8'h0, 1);
    chk("R8 pop data", {8'h0, rx_rdata}, 16'h005A);
    chk("R8 pop status", status, 16'h4100);
    cyc(0, 8'h0, 0, 0, 8'h0, 1);
    chk("R6 disabled empty pop", {8'h0, rx_rdata}, 16'h005A);

    summary();
    $finish;
  end
endmodule